// File: doc/BRIEF.md
# Interrupt Request and End-of-Interrupt Engine

This block sits between a set of interrupt pins and the message fabric that carries interrupts to processors. Each pin has a programmable redirection entry: vector, destination, destination mode, delivery mode, trigger kind (edge or level) and a mask bit. Line-level changes reach the block as one operation per cycle, and each operation names a pin and a level. The block keeps a request bit per pin and, for level pins, a remote-pending flag. From these it decides when to issue an interrupt message. It also reports, for every operation, whether the assertion was absorbed into one that was already outstanding.

Messages leave through a valid/ready handshake. When the handshake completes, the fabric returns the number of targets that took the message. For level pins, that count decides whether the remote-pending flag is set. End-of-interrupt broadcasts carry a vector. They release the remote-pending flag of every level entry with that vector, and they cause a new delivery if the line is still asserted. Writing an entry also re-evaluates the pin.

Top module: `irq_dispatch`

## Requirements
- R1: After reset every entry is masked and edge-triggered with all other fields zero, all request bits and remote-pending flags are 0, and `msg_valid_o` and `st_valid_o` are 0. An assertion on a pin that has not been reprogrammed sets its request bit and sends nothing.
- R2: An operation with level 0 clears the pin's request bit and is reported as not coalesced (`st_coalesced_o`=0).
- R3: On an edge pin (entry level field 0), an assertion while the request bit is already set is reported as coalesced (`st_coalesced_o`=1) and adds no message.
- R4: On a level pin (entry level field 1), an assertion while the remote-pending flag is set is reported as coalesced and sends no message. The request bit still becomes set.
- R5: A masked entry (mask field 1) issues no message and keeps its request bit set. A later write that clears the mask delivers the pending interrupt.
- R6: When an edge interrupt is launched, its request bit is cleared in the same cycle that `msg_valid_o` rises.
- R7: A level message whose handshake returns a nonzero accepted count sets that pin's remote-pending flag in the next cycle. A count of 0 leaves the flag clear and does not cause a repeat delivery.
- R8: An end-of-interrupt with vector V clears the remote-pending flag of every level entry whose vector is V, and re-sends any such pin whose request bit is set. Entries with other vectors are unaffected.
- R9: A configuration write clears the pin's remote-pending flag. If the new entry is level-triggered and the request bit is set, the pin is delivered again with the new fields.
- R10: When several pins are ready, the lowest-numbered pin is sent first. Only one message is outstanding at a time, and its fields stay stable until `msg_ready_i` is seen.
- R11: Every operation produces a status pulse on `st_valid_o` exactly one cycle later, and `st_pin_o` repeats the operation's pin.
- R12: The message's destination, destination mode, delivery mode, vector and trigger kind equal the pin's entry fields at the time of launch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | A line-level operation is presented this cycle |
| req_pin_i | input | PIN_W | Pin of the operation |
| req_level_i | input | 1 | New line level: 1 asserts, 0 deasserts |
| cfg_we_i | input | 1 | Write one redirection entry |
| cfg_pin_i | input | PIN_W | Entry being written |
| cfg_vector_i | input | VEC_W | New vector |
| cfg_dest_i | input | DEST_W | New destination identifier |
| cfg_dmode_i | input | 1 | New destination mode |
| cfg_dlv_i | input | DLV_W | New delivery mode |
| cfg_level_i | input | 1 | New trigger kind: 1 level, 0 edge |
| cfg_mask_i | input | 1 | New mask bit |
| eoi_valid_i | input | 1 | End-of-interrupt broadcast |
| eoi_vector_i | input | VEC_W | Vector being retired |
| msg_valid_o | output | 1 | Interrupt message is offered |
| msg_ready_i | input | 1 | Fabric takes the message |
| msg_accept_cnt_i | input | CNT_W | Number of targets that accepted, sampled with the handshake |
| msg_pin_o | output | PIN_W | Pin the message belongs to |
| msg_vector_o | output | VEC_W | Message vector |
| msg_dest_o | output | DEST_W | Message destination |
| msg_dmode_o | output | 1 | Message destination mode |
| msg_dlv_o | output | DLV_W | Message delivery mode |
| msg_level_o | output | 1 | Message trigger kind |
| st_valid_o | output | 1 | Status of the previous cycle's operation |
| st_pin_o | output | PIN_W | Pin of that operation |
| st_coalesced_o | output | 1 | The assertion was coalesced |
| irr_o | output | NPIN | Request bits |
| rirr_o | output | NPIN | Remote-pending flags |

## Verification
The hardest state to reach is a level pin whose request bit is set while its remote-pending flag is also set. Only that state lets an end-of-interrupt or an entry rewrite cause a re-delivery. The stimulus gets there by delivering a level interrupt with a nonzero accepted count, deasserting the line, and then asserting it again. That last assertion is coalesced but leaves the request bit set, which is the state that the end-of-interrupt and the rewrite then act on. Edge coalescing needs a request bit that survives, so the edge pin is first held masked. Priority is observed by stalling the handshake while two lower pins become ready behind an outstanding message.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
  parameter int VEC_W  = 8;
  parameter int DEST_W = 8;
  parameter int DLV_W  = 3;

  typedef struct packed {
    logic [DEST_W-1:0] dest;
    logic              dmode;
    logic [DLV_W-1:0]  dlv;
    logic [VEC_W-1:0]  vector;
    logic              level;
    logic              mask;
  } irqd_entry_t;

  localparam irqd_entry_t ENTRY_RST = '{dest: '0, dmode: 1'b0, dlv: '0,
                                        vector: '0, level: 1'b0, mask: 1'b1};

  // An assertion is absorbed when the pin already has an outstanding event
  function automatic logic entry_coalesces(irqd_entry_t e, logic irr, logic rirr);
    return e.level ? rirr : irr;
  endfunction

  // A pin may launch when unmasked and requested; level pins also need a
  // trigger event and no outstanding remote acknowledge
  function automatic logic entry_ready(irqd_entry_t e, logic irr, logic rirr, logic kick);
    logic gate;
    gate = e.level ? (kick & ~rirr) : 1'b1;
    return ~e.mask & irr & gate;
  endfunction
endpackage

// File: rtl/irqd_entry_table.sv
module irqd_entry_table
  import irqd_pkg::*;
#(
  parameter int NPIN  = 8,
  parameter int PIN_W = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en_i,
  input  logic [PIN_W-1:0]       wr_pin_i,
  input  irqd_entry_t            wr_entry_i,
  output irqd_entry_t [NPIN-1:0] ent_o
);
  for (genvar g = 0; g < NPIN; g++) begin : g_ent
    irqd_entry_t ent_q;
    always_ff @(posedge clk) begin
      if (!rst_n)
        ent_q <= ENTRY_RST;
      else if (wr_en_i && (wr_pin_i == PIN_W'(g)))
        ent_q <= wr_entry_i;
    end
    assign ent_o[g] = ent_q;
  end
endmodule

// File: rtl/irqd_pin_ctl.sv
module irqd_pin_ctl
  import irqd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  irqd_entry_t      ent_i,
  input  logic             req_hit_i,
  input  logic             req_level_i,
  input  logic             cfg_hit_i,
  input  logic             cfg_level_i,
  input  logic             eoi_valid_i,
  input  logic [VEC_W-1:0] eoi_vector_i,
  input  logic             launch_hit_i,
  input  logic             remote_set_i,
  output logic             irr_o,
  output logic             rirr_o,
  output logic             ready_o,
  output logic             coal_o
);
  logic irr_q, rirr_q, kick_q;
  logic irr_d, rirr_d, kick_d;
  logic eoi_hit;

  assign eoi_hit = eoi_valid_i && ent_i.level && (ent_i.vector == eoi_vector_i);
  assign coal_o  = req_level_i && entry_coalesces(ent_i, irr_q, rirr_q);
  assign ready_o = entry_ready(ent_i, irr_q, rirr_q, kick_q);

  always_comb begin
    irr_d  = irr_q;
    rirr_d = rirr_q;
    kick_d = kick_q;
    if (launch_hit_i) begin
      kick_d = 1'b0;
      if (!ent_i.level) irr_d = 1'b0;
    end
    if (req_hit_i) begin
      if (!req_level_i) begin
        irr_d  = 1'b0;
        kick_d = 1'b0;
      end else if (!coal_o) begin
        irr_d = 1'b1;
        if (ent_i.level) kick_d = 1'b1;
      end else if (ent_i.level) begin
        irr_d = 1'b1;
      end
    end
    if (eoi_hit) begin
      rirr_d = 1'b0;
      if (irr_d) kick_d = 1'b1;
    end
    if (cfg_hit_i) begin
      rirr_d = 1'b0;
      if (cfg_level_i && irr_d) kick_d = 1'b1;
    end
    if (remote_set_i) rirr_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irr_q  <= 1'b0;
      rirr_q <= 1'b0;
      kick_q <= 1'b0;
    end else begin
      irr_q  <= irr_d;
      rirr_q <= rirr_d;
      kick_q <= kick_d;
    end
  end

  assign irr_o  = irr_q;
  assign rirr_o = rirr_q;
endmodule

// File: rtl/irqd_pick.sv
module irqd_pick #(
  parameter int NPIN  = 8,
  parameter int PIN_W = 3
) (
  input  logic [NPIN-1:0]  ready_i,
  output logic             found_o,
  output logic [PIN_W-1:0] idx_o
);
  // Scan downward so the lowest set bit is the last one written
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = NPIN - 1; i >= 0; i--) begin
      if (ready_i[i]) begin
        found_o = 1'b1;
        idx_o   = PIN_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_dispatch.sv
module irq_dispatch
  import irqd_pkg::*;
#(
  parameter int NPIN  = 8,
  parameter int CNT_W = 4,
  localparam int PIN_W = (NPIN > 1) ? $clog2(NPIN) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid_i,
  input  logic [PIN_W-1:0]  req_pin_i,
  input  logic              req_level_i,
  input  logic              cfg_we_i,
  input  logic [PIN_W-1:0]  cfg_pin_i,
  input  logic [VEC_W-1:0]  cfg_vector_i,
  input  logic [DEST_W-1:0] cfg_dest_i,
  input  logic              cfg_dmode_i,
  input  logic [DLV_W-1:0]  cfg_dlv_i,
  input  logic              cfg_level_i,
  input  logic              cfg_mask_i,
  input  logic              eoi_valid_i,
  input  logic [VEC_W-1:0]  eoi_vector_i,
  output logic              msg_valid_o,
  input  logic              msg_ready_i,
  input  logic [CNT_W-1:0]  msg_accept_cnt_i,
  output logic [PIN_W-1:0]  msg_pin_o,
  output logic [VEC_W-1:0]  msg_vector_o,
  output logic [DEST_W-1:0] msg_dest_o,
  output logic              msg_dmode_o,
  output logic [DLV_W-1:0]  msg_dlv_o,
  output logic              msg_level_o,
  output logic              st_valid_o,
  output logic [PIN_W-1:0]  st_pin_o,
  output logic              st_coalesced_o,
  output logic [NPIN-1:0]   irr_o,
  output logic [NPIN-1:0]   rirr_o
);
  irqd_entry_t [NPIN-1:0] ent;
  irqd_entry_t            wr_entry;
  logic [NPIN-1:0]        ready_vec;
  logic [NPIN-1:0]        coal_vec;
  logic [NPIN-1:0]        ent_level_vec;
  logic [NPIN-1:0]        ent_mask_vec;
  logic [NPIN*VEC_W-1:0]  ent_vec_flat;
  logic                   pick_found;
  logic [PIN_W-1:0]       pick_idx;
  logic                   launch_w;
  logic                   handshake_w;
  logic                   accepted_w;

  irqd_entry_t      msg_q;
  logic             msg_valid_q;
  logic [PIN_W-1:0] msg_pin_q;
  logic             st_valid_q;
  logic [PIN_W-1:0] st_pin_q;
  logic             st_coal_q;

  assign wr_entry = '{dest: cfg_dest_i, dmode: cfg_dmode_i, dlv: cfg_dlv_i,
                      vector: cfg_vector_i, level: cfg_level_i, mask: cfg_mask_i};

  irqd_entry_table #(.NPIN(NPIN), .PIN_W(PIN_W)) u_table (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en_i    (cfg_we_i),
    .wr_pin_i   (cfg_pin_i),
    .wr_entry_i (wr_entry),
    .ent_o      (ent)
  );

  assign handshake_w = msg_valid_q && msg_ready_i;
  assign accepted_w  = |msg_accept_cnt_i;
  assign launch_w    = !msg_valid_q && pick_found;

  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    assign ent_level_vec[g]                 = ent[g].level;
    assign ent_mask_vec[g]                  = ent[g].mask;
    assign ent_vec_flat[g*VEC_W +: VEC_W]   = ent[g].vector;

    irqd_pin_ctl u_ctl (
      .clk          (clk),
      .rst_n        (rst_n),
      .ent_i        (ent[g]),
      .req_hit_i    (req_valid_i && (req_pin_i == PIN_W'(g))),
      .req_level_i  (req_level_i),
      .cfg_hit_i    (cfg_we_i && (cfg_pin_i == PIN_W'(g))),
      .cfg_level_i  (cfg_level_i),
      .eoi_valid_i  (eoi_valid_i),
      .eoi_vector_i (eoi_vector_i),
      .launch_hit_i (launch_w && (pick_idx == PIN_W'(g))),
      .remote_set_i (handshake_w && msg_q.level && accepted_w && (msg_pin_q == PIN_W'(g))),
      .irr_o        (irr_o[g]),
      .rirr_o       (rirr_o[g]),
      .ready_o      (ready_vec[g]),
      .coal_o       (coal_vec[g])
    );
  end

  irqd_pick #(.NPIN(NPIN), .PIN_W(PIN_W)) u_pick (
    .ready_i (ready_vec),
    .found_o (pick_found),
    .idx_o   (pick_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msg_valid_q <= 1'b0;
      msg_q       <= '0;
      msg_pin_q   <= '0;
    end else if (launch_w) begin
      msg_valid_q <= 1'b1;
      msg_q       <= ent[pick_idx];
      msg_pin_q   <= pick_idx;
    end else if (handshake_w) begin
      msg_valid_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_valid_q <= 1'b0;
      st_pin_q   <= '0;
      st_coal_q  <= 1'b0;
    end else begin
      st_valid_q <= req_valid_i;
      st_pin_q   <= req_pin_i;
      st_coal_q  <= req_valid_i && coal_vec[req_pin_i];
    end
  end

  assign msg_valid_o    = msg_valid_q;
  assign msg_pin_o      = msg_pin_q;
  assign msg_vector_o   = msg_q.vector;
  assign msg_dest_o     = msg_q.dest;
  assign msg_dmode_o    = msg_q.dmode;
  assign msg_dlv_o      = msg_q.dlv;
  assign msg_level_o    = msg_q.level;
  assign st_valid_o     = st_valid_q;
  assign st_pin_o       = st_pin_q;
  assign st_coalesced_o = st_coal_q;
endmodule

// File: rtl/irq_dispatch_chk.sv
module irq_dispatch_chk
  import irqd_pkg::*;
#(
  parameter int NPIN  = 8,
  parameter int CNT_W = 4,
  parameter int PIN_W = 3
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  req_valid_i,
  input logic [PIN_W-1:0]      req_pin_i,
  input logic                  eoi_valid_i,
  input logic [VEC_W-1:0]      eoi_vector_i,
  input logic                  msg_valid_o,
  input logic                  msg_ready_i,
  input logic [CNT_W-1:0]      msg_accept_cnt_i,
  input logic [PIN_W-1:0]      msg_pin_o,
  input logic [VEC_W-1:0]      msg_vector_o,
  input logic [DEST_W-1:0]     msg_dest_o,
  input logic                  msg_level_o,
  input logic                  st_valid_o,
  input logic [PIN_W-1:0]      st_pin_o,
  input logic [NPIN-1:0]       irr_o,
  input logic [NPIN-1:0]       rirr_o,
  input logic [NPIN-1:0]       ent_level_vec,
  input logic [NPIN-1:0]       ent_mask_vec,
  input logic [NPIN*VEC_W-1:0] ent_vec_flat
);
  logic [NPIN-1:0] mask_prev;
  always_ff @(posedge clk) mask_prev <= ent_mask_vec;

  a_r10_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid_o && !msg_ready_i |=> msg_valid_o && $stable(msg_pin_o)
      && $stable(msg_vector_o) && $stable(msg_dest_o));

  a_r6_edge_request_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msg_valid_o) && !msg_level_o |-> !irr_o[msg_pin_o]);

  a_r5_never_from_masked: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msg_valid_o) |-> !mask_prev[msg_pin_o]);

  a_r7_remote_set: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid_o && msg_ready_i && msg_level_o && (msg_accept_cnt_i != '0)
      |=> rirr_o[$past(msg_pin_o)]);

  a_r7_failed_stays_clear: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid_o && msg_ready_i && (msg_accept_cnt_i == '0)
      |=> !rirr_o[$past(msg_pin_o)]);

  a_r11_status_follows: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid_o |-> $past(req_valid_i) && (st_pin_o == $past(req_pin_i)));

  for (genvar g = 0; g < NPIN; g++) begin : g_eoi
    a_r8_eoi_releases: assert property (@(posedge clk) disable iff (!rst_n)
      eoi_valid_i && ent_level_vec[g] && (ent_vec_flat[g*VEC_W +: VEC_W] == eoi_vector_i)
        && !(msg_valid_o && msg_ready_i && (msg_pin_o == PIN_W'(g)))
        |=> !rirr_o[g]);
  end
endmodule

bind irq_dispatch irq_dispatch_chk #(.NPIN(NPIN), .CNT_W(CNT_W), .PIN_W(PIN_W)) u_chk (.*);

// File: tb/irq_dispatch_bench.sv
module irq_dispatch_bench;
  import irqd_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int NPIN  = 8;
  localparam int CNT_W = 4;
  localparam int PIN_W = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid_i = 0, req_level_i = 0;
  logic [PIN_W-1:0] req_pin_i = '0;
  logic cfg_we_i = 0, cfg_dmode_i = 0, cfg_level_i = 0, cfg_mask_i = 0;
  logic [PIN_W-1:0] cfg_pin_i = '0;
  logic [VEC_W-1:0] cfg_vector_i = '0;
  logic [DEST_W-1:0] cfg_dest_i = '0;
  logic [DLV_W-1:0] cfg_dlv_i = '0;
  logic eoi_valid_i = 0;
  logic [VEC_W-1:0] eoi_vector_i = '0;
  logic msg_ready_i = 0;
  logic [CNT_W-1:0] msg_accept_cnt_i = '0;
  logic msg_valid_o, msg_dmode_o, msg_level_o;
  logic [PIN_W-1:0] msg_pin_o, st_pin_o;
  logic [VEC_W-1:0] msg_vector_o;
  logic [DEST_W-1:0] msg_dest_o;
  logic [DLV_W-1:0] msg_dlv_o;
  logic st_valid_o, st_coalesced_o;
  logic [NPIN-1:0] irr_o, rirr_o;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_dispatch #(.NPIN(NPIN), .CNT_W(CNT_W)) u_irq_dispatch (.*);

  typedef struct packed {
    logic [3:0] pin;
    logic       lvl;
    logic       coal;
    logic       send;
    logic [3:0] acc;
    logic [7:0] vec;
    logic       islvl;
  } row_t;

  // pin 0: edge, vector 0x30; pin 1: level, vector 0x41
  localparam row_t ROWS [7] = '{
    '{4'd0, 1'b1, 1'b0, 1'b1, 4'd1, 8'h30, 1'b0},
    '{4'd0, 1'b1, 1'b0, 1'b1, 4'd1, 8'h30, 1'b0},
    '{4'd0, 1'b0, 1'b0, 1'b0, 4'd0, 8'h30, 1'b0},
    '{4'd1, 1'b1, 1'b0, 1'b1, 4'd2, 8'h41, 1'b1},
    '{4'd1, 1'b1, 1'b1, 1'b0, 4'd0, 8'h41, 1'b1},
    '{4'd1, 1'b0, 1'b0, 1'b0, 4'd0, 8'h41, 1'b1},
    '{4'd1, 1'b1, 1'b1, 1'b0, 4'd0, 8'h41, 1'b1}
  };

  function automatic logic [DEST_W-1:0] dest_of(int p); return DEST_W'(p * 17 + 3); endfunction
  function automatic logic [DLV_W-1:0] dlv_of(int p); return DLV_W'(7 - p); endfunction
  function automatic logic dmode_of(int p); return p[0]; endfunction

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      failures++;
      $display("FAIL watchdog: actual=%0d cycles expected<=20000", cycles);
      summary();
    end
  end

  task automatic chk(input logic ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic cfg(input int p, input int vec, input logic lvl, input logic msk);
    @(negedge clk);
    cfg_we_i = 1; cfg_pin_i = PIN_W'(p); cfg_vector_i = VEC_W'(vec);
    cfg_dest_i = dest_of(p); cfg_dmode_i = dmode_of(p); cfg_dlv_i = dlv_of(p);
    cfg_level_i = lvl; cfg_mask_i = msk;
    @(negedge clk);
    cfg_we_i = 0;
  endtask

  task automatic do_req(input int p, input logic lvl, input logic exp_coal, input string tag);
    @(negedge clk);
    req_valid_i = 1; req_pin_i = PIN_W'(p); req_level_i = lvl;
    @(negedge clk);
    req_valid_i = 0;
    chk(st_valid_o == 1'b1, {tag, " R11 status valid"}, st_valid_o, 1);
    chk(st_pin_o == PIN_W'(p), {tag, " R11 status pin"}, st_pin_o, p);
    chk(st_coalesced_o == exp_coal, {tag, " coalesced flag"}, st_coalesced_o, exp_coal);
  endtask

  task automatic wait_msg(output logic got);
    got = 0;
    for (int i = 0; i < 6; i++) begin
      if (msg_valid_o) begin got = 1; break; end
      @(negedge clk);
    end
  endtask

  task automatic take_msg(input int p, input int vec, input logic lvl, input int acc, input string tag);
    logic got;
    wait_msg(got);
    chk(got, {tag, " message offered"}, got, 1);
    if (got) begin
      chk(msg_pin_o == PIN_W'(p), {tag, " R10 message pin"}, msg_pin_o, p);
      chk(msg_vector_o == VEC_W'(vec), {tag, " R12 vector"}, msg_vector_o, vec);
      chk(msg_level_o == lvl, {tag, " R12 trigger kind"}, msg_level_o, lvl);
      chk(msg_dest_o == dest_of(p) && msg_dlv_o == dlv_of(p) && msg_dmode_o == dmode_of(p),
          {tag, " R12 destination fields"}, {msg_dest_o, msg_dlv_o, msg_dmode_o},
          {dest_of(p), dlv_of(p), dmode_of(p)});
      msg_ready_i = 1; msg_accept_cnt_i = CNT_W'(acc);
      @(negedge clk);
      msg_ready_i = 0; msg_accept_cnt_i = '0;
      chk(msg_valid_o == 1'b0, {tag, " R10 single outstanding"}, msg_valid_o, 0);
    end
  endtask

  task automatic quiet(input int n, input string tag);
    logic seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (msg_valid_o) seen = 1;
    end
    chk(!seen, {tag, " no message"}, seen, 0);
  endtask

  task automatic eoi(input int vec);
    @(negedge clk);
    eoi_valid_i = 1; eoi_vector_i = VEC_W'(vec);
    @(negedge clk);
    eoi_valid_i = 0;
  endtask

  task automatic walk_table();
    row_t r;
    for (int i = 0; i < 7; i++) begin
      r = ROWS[i];
      do_req(int'(r.pin), r.lvl, r.coal, r.coal ? (r.islvl ? "R4 row" : "R3 row") : "R2 row");
      if (r.send) begin
        take_msg(int'(r.pin), int'(r.vec), r.islvl, int'(r.acc), "table");
        if (r.islvl)
          chk(rirr_o[r.pin] == 1'b1, "R7 remote-pending set", rirr_o[r.pin], 1);
        else
          chk(irr_o[r.pin] == 1'b0, "R6 edge request cleared", irr_o[r.pin], 0);
      end else begin
        quiet(4, r.coal ? "R4 coalesced" : "R2 deassert");
        if (!r.lvl) chk(irr_o[r.pin] == 1'b0, "R2 request cleared", irr_o[r.pin], 0);
        else chk(irr_o[r.pin] == 1'b1, "R4 request kept", irr_o[r.pin], 1);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(msg_valid_o == 0 && st_valid_o == 0, "R1 outputs idle", {msg_valid_o, st_valid_o}, 0);
    chk(irr_o == '0 && rirr_o == '0, "R1 state clear", {irr_o, rirr_o}, 0);
    do_req(4, 1'b1, 1'b0, "R1 masked default");
    quiet(4, "R1 masked default");
    chk(irr_o[4] == 1'b1, "R1 request held", irr_o[4], 1);
    do_req(4, 1'b0, 1'b0, "R2 deassert");
    chk(irr_o[4] == 1'b0, "R2 request cleared", irr_o[4], 0);

    cfg(0, 'h30, 1'b0, 1'b0);
    cfg(1, 'h41, 1'b1, 1'b0);
    walk_table();

    eoi('h99);
    quiet(4, "R8 other vector");
    chk(rirr_o[1] == 1'b1, "R8 other vector keeps flag", rirr_o[1], 1);
    eoi('h41);
    chk(rirr_o[1] == 1'b0, "R8 flag released", rirr_o[1], 0);
    take_msg(1, 'h41, 1'b1, 1, "R8 redelivery");
    chk(rirr_o[1] == 1'b1, "R8 flag set again", rirr_o[1], 1);

    cfg(1, 'h43, 1'b1, 1'b0);
    chk(rirr_o[1] == 1'b0, "R9 write clears flag", rirr_o[1], 0);
    take_msg(1, 'h43, 1'b1, 1, "R9 re-evaluation");

    cfg(2, 'h52, 1'b1, 1'b0);
    do_req(2, 1'b1, 1'b0, "R7 failing target");
    take_msg(2, 'h52, 1'b1, 0, "R7 zero accepted");
    chk(rirr_o[2] == 1'b0, "R7 flag stays clear", rirr_o[2], 0);
    quiet(4, "R7 no repeat");

    cfg(3, 'h63, 1'b0, 1'b1);
    do_req(3, 1'b1, 1'b0, "R5 masked edge");
    quiet(4, "R5 masked");
    chk(irr_o[3] == 1'b1, "R5 request kept", irr_o[3], 1);
    do_req(3, 1'b1, 1'b1, "R3 edge coalesced");
    cfg(3, 'h63, 1'b0, 1'b0);
    take_msg(3, 'h63, 1'b0, 1, "R5 unmask delivers");
    quiet(4, "R3 one message only");
    chk(irr_o[3] == 1'b0, "R6 cleared after send", irr_o[3], 0);

    cfg(6, 'h76, 1'b0, 1'b0);
    cfg(5, 'h75, 1'b0, 1'b0);
    do_req(6, 1'b1, 1'b0, "R10 first");
    do_req(5, 1'b1, 1'b0, "R10 second");
    do_req(3, 1'b1, 1'b0, "R10 third");
    repeat (3) @(negedge clk);
    chk(msg_valid_o && msg_pin_o == 3'd6, "R10 held while stalled", msg_pin_o, 6);
    take_msg(6, 'h76, 1'b0, 1, "R10 stalled");
    take_msg(3, 'h63, 1'b0, 1, "R10 lowest first");
    take_msg(5, 'h75, 1'b0, 1, "R10 then next");
    quiet(4, "R10 drained");

    summary();
  end
endmodule